// File: doc/BRIEF.md
# 64-bit Integer Operate Unit

This block is the integer execution stage of a 64-bit load/store core. Each cycle it may accept one decoded operate instruction: a function code, the values and indices of two source registers, an optional 8-bit literal that replaces the second source, a per-instruction overflow-trap enable and a destination index. It returns a 64-bit result with a write enable and an overflow-trap request. It also raises a flag when the function code is undefined.

Almost every operation finishes combinationally in the issue cycle. The exception is the unsigned multiply-high. Its result is registered and comes out one cycle later on a separate write-back port that carries its own valid strobe. The register file, byte manipulation, floating point and divide belong to other blocks.

Top module: `int_exec_unit`

## Requirements
- R1: A source whose register index is 31 reads as zero, whatever value is presented for it.
- R2: When `lit_en_i` is 1, the second operand is `lit_i` zero-extended to 64 bits, and the RB value is ignored.
- R3: Quadword add (code 0) and subtract (code 1) wrap modulo 2^64. Longword add (code 2) and subtract (code 3) use only the low 32 bits of each operand.
- R4: Longword results (codes 2, 3 and 4) return bit 31 copied into bits 63:32.
- R5: Signed overflow sets `ovf_trap_o` only when `trap_en_i` is 1. Longword operations overflow when the exact 32-bit signed result does not fit. Quadword operations use the 64-bit signed limit.
- R6: Longword multiply (code 4) returns the signed product of the low 32-bit halves. Quadword multiply (code 5) returns the low 64 bits of the product. Both can overflow under R5.
- R7: Unsigned multiply-high (code 6) gives no issue-cycle result. After the next rising edge, `mul_valid_o` is high for one cycle and `mul_res_o` holds bits 127:64 of the unsigned product.
- R8: Scaled operations compute RA times 4 plus RB (code 7), RA times 8 plus RB (code 8), RA times 4 minus RB (code 9) and RA times 8 minus RB (code 10). None of them traps.
- R9: Compares return 1 or 0: equal (11), signed less (12), signed less-or-equal (13), unsigned less (14).
- R10: The logic and shift operations are AND (15), AND-NOT (16), OR (17), XOR (18), shift left (19), logical right (20) and arithmetic right (21). Shift counts use only bits 5:0 of the second operand.
- R11: A conditional move passes RB as the result and asserts `wr_en_o` only when RA satisfies its test: zero (22), nonzero (23), negative (24) or non-negative (25). Otherwise `wr_en_o` stays low.
- R12: Function codes above 25 assert `illegal_o`, and keep `res_valid_o`, `wr_en_o` and `ovf_trap_o` low.
- R13: A destination index of 31 keeps `wr_en_o` and `mul_wr_en_o` low. The result and its valid strobe are still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| func_i | input | 6 | Function code |
| ra_idx_i | input | 5 | First source index |
| ra_val_i | input | 64 | First source value |
| rb_idx_i | input | 5 | Second source index |
| rb_val_i | input | 64 | Second source value |
| lit_en_i | input | 1 | Use the literal as the second operand |
| lit_i | input | 8 | Literal value |
| trap_en_i | input | 1 | Overflow trap enable for this instruction |
| rc_idx_i | input | 5 | Destination index |
| res_valid_o | output | 1 | Issue-cycle result is valid |
| res_o | output | 64 | Issue-cycle result |
| wr_en_o | output | 1 | Write issue-cycle result to `wr_idx_o` |
| wr_idx_o | output | 5 | Destination index of the issue-cycle result |
| ovf_trap_o | output | 1 | Overflow trap request |
| illegal_o | output | 1 | Undefined function code |
| mul_valid_o | output | 1 | Multiply-high result valid |
| mul_res_o | output | 64 | Multiply-high result |
| mul_wr_en_o | output | 1 | Write the multiply-high result |
| mul_idx_o | output | 5 | Destination index of the multiply-high result |

## Verification
Issue-cycle results, write enables, trap and illegal flags are all combinational. The bench therefore applies each instruction at a falling edge and samples these outputs shortly after, before the next rising edge. The multiply-high result passes through one register. It is checked just after the first rising edge that follows issue. It is checked again one edge later, after `issue_i` has been dropped, to confirm that the strobe has cleared.

// File: rtl/iex_pkg.sv
package iex_pkg;
    parameter int FUNC_W = 6;

    typedef enum logic [FUNC_W-1:0] {
        F_ADDQ   = 6'd0,  F_SUBQ   = 6'd1,  F_ADDL   = 6'd2,  F_SUBL   = 6'd3,
        F_MULL   = 6'd4,  F_MULQ   = 6'd5,  F_UMULH  = 6'd6,
        F_S4ADD  = 6'd7,  F_S8ADD  = 6'd8,  F_S4SUB  = 6'd9,  F_S8SUB  = 6'd10,
        F_CMPEQ  = 6'd11, F_CMPLT  = 6'd12, F_CMPLE  = 6'd13, F_CMPULT = 6'd14,
        F_AND    = 6'd15, F_BIC    = 6'd16, F_OR     = 6'd17, F_XOR    = 6'd18,
        F_SLL    = 6'd19, F_SRL    = 6'd20, F_SRA    = 6'd21,
        F_CMOVEQ = 6'd22, F_CMOVNE = 6'd23, F_CMOVLT = 6'd24, F_CMOVGE = 6'd25
    } iex_func_e;
endpackage

// File: rtl/iex_opsel.sv
module iex_opsel #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    parameter int LIT_W  = 8
) (
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [DATA_W-1:0] ra_val_i,
    input  logic [IDX_W-1:0]  rb_idx_i,
    input  logic [DATA_W-1:0] rb_val_i,
    input  logic              lit_en_i,
    input  logic [LIT_W-1:0]  lit_i,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o
);
    localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

    always_comb begin
        opa_o = (ra_idx_i == ZERO_IDX) ? '0 : ra_val_i;
        if (lit_en_i)
            opb_o = {{(DATA_W-LIT_W){1'b0}}, lit_i};
        else
            opb_o = (rb_idx_i == ZERO_IDX) ? '0 : rb_val_i;
    end
endmodule

// File: rtl/iex_alu.sv
module iex_alu
    import iex_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [FUNC_W-1:0] func_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ovf_o,
    output logic              illegal_o,
    output logic              cond_ok_o,
    output logic              is_mulhi_o
);
    localparam int HALF = DATA_W / 2;
    localparam int SH_W = $clog2(DATA_W);
    localparam int SC4  = 2;
    localparam int SC8  = 3;

    function automatic logic [DATA_W-1:0] sext_half(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction

    logic [DATA_W-1:0]   sum_d, dif_d, lprod_d;
    logic [HALF:0]       lsum_d, ldif_d;
    logic [2*DATA_W-1:0] qprod_d;
    logic [SH_W-1:0]     sh_d;
    logic                a_neg, b_neg, s_neg, d_neg;

    always_comb begin
        sum_d   = opa_i + opb_i;
        dif_d   = opa_i - opb_i;
        lsum_d  = {opa_i[HALF-1], opa_i[HALF-1:0]} + {opb_i[HALF-1], opb_i[HALF-1:0]};
        ldif_d  = {opa_i[HALF-1], opa_i[HALF-1:0]} - {opb_i[HALF-1], opb_i[HALF-1:0]};
        lprod_d = sext_half(opa_i[HALF-1:0]) * sext_half(opb_i[HALF-1:0]);
        qprod_d = {{DATA_W{opa_i[DATA_W-1]}}, opa_i} * {{DATA_W{opb_i[DATA_W-1]}}, opb_i};
        sh_d    = opb_i[SH_W-1:0];
        a_neg   = opa_i[DATA_W-1];
        b_neg   = opb_i[DATA_W-1];
        s_neg   = sum_d[DATA_W-1];
        d_neg   = dif_d[DATA_W-1];

        res_o      = '0;
        ovf_o      = 1'b0;
        illegal_o  = 1'b0;
        cond_ok_o  = 1'b1;
        is_mulhi_o = 1'b0;

        case (func_i)
            F_ADDQ: begin
                res_o = sum_d;
                ovf_o = (a_neg == b_neg) && (s_neg != a_neg);
            end
            F_SUBQ: begin
                res_o = dif_d;
                ovf_o = (a_neg != b_neg) && (d_neg != a_neg);
            end
            F_ADDL: begin
                res_o = sext_half(lsum_d[HALF-1:0]);
                ovf_o = lsum_d[HALF] != lsum_d[HALF-1];
            end
            F_SUBL: begin
                res_o = sext_half(ldif_d[HALF-1:0]);
                ovf_o = ldif_d[HALF] != ldif_d[HALF-1];
            end
            F_MULL: begin
                res_o = sext_half(lprod_d[HALF-1:0]);
                ovf_o = lprod_d[DATA_W-1:HALF-1] != {(HALF+1){lprod_d[HALF-1]}};
            end
            F_MULQ: begin
                res_o = qprod_d[DATA_W-1:0];
                ovf_o = qprod_d[2*DATA_W-1:DATA_W] != {DATA_W{qprod_d[DATA_W-1]}};
            end
            F_UMULH:  is_mulhi_o = 1'b1;
            F_S4ADD:  res_o = (opa_i << SC4) + opb_i;
            F_S8ADD:  res_o = (opa_i << SC8) + opb_i;
            F_S4SUB:  res_o = (opa_i << SC4) - opb_i;
            F_S8SUB:  res_o = (opa_i << SC8) - opb_i;
            F_CMPEQ:  res_o = {{(DATA_W-1){1'b0}}, opa_i == opb_i};
            F_CMPLT:  res_o = {{(DATA_W-1){1'b0}}, $signed(opa_i) < $signed(opb_i)};
            F_CMPLE:  res_o = {{(DATA_W-1){1'b0}}, $signed(opa_i) <= $signed(opb_i)};
            F_CMPULT: res_o = {{(DATA_W-1){1'b0}}, opa_i < opb_i};
            F_AND:    res_o = opa_i & opb_i;
            F_BIC:    res_o = opa_i & ~opb_i;
            F_OR:     res_o = opa_i | opb_i;
            F_XOR:    res_o = opa_i ^ opb_i;
            F_SLL:    res_o = opa_i << sh_d;
            F_SRL:    res_o = opa_i >> sh_d;
            F_SRA:    res_o = $signed(opa_i) >>> sh_d;
            F_CMOVEQ: begin res_o = opb_i; cond_ok_o = (opa_i == '0); end
            F_CMOVNE: begin res_o = opb_i; cond_ok_o = (opa_i != '0); end
            F_CMOVLT: begin res_o = opb_i; cond_ok_o = a_neg;         end
            F_CMOVGE: begin res_o = opb_i; cond_ok_o = !a_neg;        end
            default:  illegal_o = 1'b1;
        endcase
    end

    // R12: an undefined code never reports overflow
    always_comb begin
        if (illegal_o) assert (!ovf_o) else $error("p_illegal_no_ovf_r12");
    end
endmodule

// File: rtl/iex_mulhi.sv
module iex_mulhi #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wr_i,
    output logic              mul_valid_o,
    output logic [DATA_W-1:0] mul_res_o,
    output logic              mul_wr_en_o,
    output logic [IDX_W-1:0]  mul_idx_o
);
    localparam int               PROD_W   = 2 * DATA_W;
    localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] hi;
    } mul_stage_t;

    mul_stage_t mul_d, mul_q;

    always_comb begin
        mul_d     = mul_q;
        mul_d.vld = start_i;
        mul_d.wr  = start_i && wr_i;
        if (start_i) begin
            mul_d.idx = idx_i;
            mul_d.hi  = DATA_W'(({{DATA_W{1'b0}}, opa_i} * {{DATA_W{1'b0}}, opb_i}) >> DATA_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_q <= '0;
        else        mul_q <= mul_d;
    end

    assign mul_valid_o = mul_q.vld;
    assign mul_wr_en_o = mul_q.wr;
    assign mul_idx_o   = mul_q.idx;
    assign mul_res_o   = mul_q.hi;

    p_mulhi_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> mul_valid_o);
    p_mulhi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !mul_valid_o);
    p_mulhi_nozero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr_en_o |-> (mul_valid_o && mul_idx_o != ZERO_IDX));
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iex_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    parameter int LIT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [5:0]        func_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [DATA_W-1:0] ra_val_i,
    input  logic [IDX_W-1:0]  rb_idx_i,
    input  logic [DATA_W-1:0] rb_val_i,
    input  logic              lit_en_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic              trap_en_i,
    input  logic [IDX_W-1:0]  rc_idx_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic              ovf_trap_o,
    output logic              illegal_o,
    output logic              mul_valid_o,
    output logic [DATA_W-1:0] mul_res_o,
    output logic              mul_wr_en_o,
    output logic [IDX_W-1:0]  mul_idx_o
);
    localparam int               HALF     = DATA_W / 2;
    localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

    logic [DATA_W-1:0] opa, opb, alu_res;
    logic              alu_ovf, alu_illegal, cond_ok, is_mulhi, dest_ok;

    iex_opsel #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LIT_W(LIT_W)) u_opsel (
        .ra_idx_i (ra_idx_i),
        .ra_val_i (ra_val_i),
        .rb_idx_i (rb_idx_i),
        .rb_val_i (rb_val_i),
        .lit_en_i (lit_en_i),
        .lit_i    (lit_i),
        .opa_o    (opa),
        .opb_o    (opb)
    );

    iex_alu #(.DATA_W(DATA_W)) u_alu (
        .func_i     (func_i),
        .opa_i      (opa),
        .opb_i      (opb),
        .res_o      (alu_res),
        .ovf_o      (alu_ovf),
        .illegal_o  (alu_illegal),
        .cond_ok_o  (cond_ok),
        .is_mulhi_o (is_mulhi)
    );

    assign dest_ok     = (rc_idx_i != ZERO_IDX);
    assign res_valid_o = issue_i && !alu_illegal && !is_mulhi;
    assign res_o       = alu_res;
    assign wr_en_o     = res_valid_o && cond_ok && dest_ok;
    assign wr_idx_o    = rc_idx_i;
    assign ovf_trap_o  = issue_i && trap_en_i && alu_ovf;
    assign illegal_o   = issue_i && alu_illegal;

    iex_mulhi #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mulhi (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (issue_i && is_mulhi),
        .opa_i       (opa),
        .opb_i       (opb),
        .idx_i       (rc_idx_i),
        .wr_i        (dest_ok),
        .mul_valid_o (mul_valid_o),
        .mul_res_o   (mul_res_o),
        .mul_wr_en_o (mul_wr_en_o),
        .mul_idx_o   (mul_idx_o)
    );

    p_canon_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && (func_i == F_ADDL || func_i == F_SUBL || func_i == F_MULL))
        |-> (res_o[DATA_W-1:HALF] == {HALF{res_o[HALF-1]}}));
    p_trap_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |-> (trap_en_i && issue_i));
    p_illegal_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !ovf_trap_o && !res_valid_o));
    p_write_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> res_valid_o);
endmodule

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
    localparam logic [5:0] ADDQ=0, SUBQ=1, ADDL=2, SUBL=3, MULL=4, MULQ=5, UMULH=6,
        S4ADD=7, S8ADD=8, S4SUB=9, S8SUB=10, CMPEQ=11, CMPLT=12, CMPLE=13, CMPULT=14,
        AND_=15, BIC=16, OR_=17, XOR_=18, SLL=19, SRL=20, SRA=21,
        CMOVEQ=22, CMOVNE=23, CMOVLT=24, CMOVGE=25;

    logic clk = 0, rst_n = 0;
    logic issue = 0, lit_en = 0, trap_en = 0;
    logic [5:0] func = 0;
    logic [4:0] ra_idx = 1, rb_idx = 2, rc_idx = 3;
    logic [63:0] ra_val = 0, rb_val = 0;
    logic [7:0] lit = 0;
    logic res_valid, wr_en, ovf_trap, illegal, mul_valid, mul_wr_en;
    logic [63:0] res, mul_res;
    logic [4:0] wr_idx, mul_idx;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    int_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .func_i(func),
        .ra_idx_i(ra_idx), .ra_val_i(ra_val), .rb_idx_i(rb_idx), .rb_val_i(rb_val),
        .lit_en_i(lit_en), .lit_i(lit), .trap_en_i(trap_en), .rc_idx_i(rc_idx),
        .res_valid_o(res_valid), .res_o(res), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .ovf_trap_o(ovf_trap), .illegal_o(illegal), .mul_valid_o(mul_valid),
        .mul_res_o(mul_res), .mul_wr_en_o(mul_wr_en), .mul_idx_o(mul_idx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] f, input logic [63:0] a, input logic [63:0] b,
                       input logic te);
        @(negedge clk);
        issue = 1; func = f; ra_val = a; rb_val = b; trap_en = te;
        ra_idx = 1; rb_idx = 2; rc_idx = 3; lit_en = 0; lit = 0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 0;
    endtask

    task automatic t_reset();
        chk("R7 reset mul_valid", 64'(mul_valid), 0);
        chk("R7 reset mul_wr_en", 64'(mul_wr_en), 0);
        chk("R12 idle wr_en", 64'(wr_en), 0);
    endtask

    task automatic t_zero_reg();
        put(ADDQ, 64'd5, 64'd7, 0);
        ra_idx = 31; #1;
        chk("R1 ra idx 31", res, 64'd7);
        ra_idx = 1; rb_idx = 31; #1;
        chk("R1 rb idx 31", res, 64'd5);
        idle();
    endtask

    task automatic t_literal();
        put(ADDQ, 64'd10, 64'd999, 0);
        lit_en = 1; lit = 8'hF0; #1;
        chk("R2 literal add", res, 64'd250);
        put(ADDQ, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        lit_en = 1; lit = 8'hFF; #1;
        chk("R2 literal zero-extend", res, 64'd255);
        idle();
    endtask

    task automatic t_quad();
        put(ADDQ, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0);
        chk("R3 addq wrap", res, 64'h8000_0000_0000_0000);
        chk("R5 no trap without enable", 64'(ovf_trap), 0);
        put(SUBQ, 64'd0, 64'd1, 1);
        chk("R3 subq", res, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 subq no overflow", 64'(ovf_trap), 0);
        idle();
    endtask

    task automatic t_long();
        put(ADDL, 64'h1234_5678_0000_0003, 64'hABCD_0000_0000_0004, 1);
        chk("R3 addl low halves", res, 64'd7);
        chk("R5 addl no ovf", 64'(ovf_trap), 0);
        put(ADDL, 64'h7FFF_FFFF, 64'd1, 1);
        chk("R4 addl canonical", res, 64'hFFFF_FFFF_8000_0000);
        chk("R5 addl overflow", 64'(ovf_trap), 1);
        put(SUBL, 64'd0, 64'd1, 1);
        chk("R4 subl canonical", res, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 subl no ovf", 64'(ovf_trap), 0);
        idle();
    endtask

    task automatic t_trap();
        put(ADDQ, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1);
        chk("R5 addq trap enabled", 64'(ovf_trap), 1);
        put(SUBQ, 64'h8000_0000_0000_0000, 64'd1, 1);
        chk("R5 subq trap", 64'(ovf_trap), 1);
        put(SUBQ, 64'h8000_0000_0000_0000, 64'd1, 0);
        chk("R5 subq disabled", 64'(ovf_trap), 0);
        idle();
    endtask

    task automatic t_mul();
        put(MULL, 64'h1_0000, 64'h1_0000, 1);
        chk("R6 mull overflow result", res, 64'd0);
        chk("R5 mull overflow", 64'(ovf_trap), 1);
        put(MULL, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 1);
        chk("R6 mull negative", res, 64'hFFFF_FFFF_FFFF_FFF1);
        chk("R5 mull no ovf", 64'(ovf_trap), 0);
        put(MULQ, 64'h1_0000_0000, 64'h1_0000_0000, 1);
        chk("R6 mulq low", res, 64'd0);
        chk("R5 mulq overflow", 64'(ovf_trap), 1);
        put(MULQ, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 1);
        chk("R6 mulq signed", res, 64'hFFFF_FFFF_FFFF_FFFA);
        chk("R5 mulq no ovf", 64'(ovf_trap), 0);
        idle();
    endtask

    task automatic t_umulh(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] p;
        p = {64'd0, a} * {64'd0, b};
        put(UMULH, a, b, 1);
        chk("R7 no issue-cycle result", 64'(res_valid), 0);
        @(posedge clk); #1;
        chk("R7 strobe after one edge", 64'(mul_valid), 1);
        chk("R7 high half", mul_res, p[127:64]);
        chk("R7 index", 64'(mul_idx), 64'd3);
        idle();
        @(posedge clk); #1;
        chk("R7 strobe clears", 64'(mul_valid), 0);
    endtask

    task automatic t_scaled();
        put(S4ADD, 64'd3, 64'd1, 1);
        chk("R8 s4add", res, 64'd13);
        put(S8ADD, 64'd3, 64'd1, 1);
        chk("R8 s8add", res, 64'd25);
        put(S4SUB, 64'd3, 64'd20, 1);
        chk("R8 s4sub", res, 64'hFFFF_FFFF_FFFF_FFF8);
        put(S8SUB, 64'd3, 64'd1, 1);
        chk("R8 s8sub", res, 64'd23);
        idle();
    endtask

    task automatic t_cmp();
        put(CMPLT, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0);
        chk("R9 signed lt", res, 64'd1);
        put(CMPULT, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0);
        chk("R9 unsigned lt", res, 64'd0);
        put(CMPEQ, 64'd5, 64'd5, 0);
        chk("R9 eq", res, 64'd1);
        put(CMPLE, 64'd5, 64'd5, 0);
        chk("R9 le", res, 64'd1);
        put(CMPLE, 64'd6, 64'd5, 0);
        chk("R9 le false", res, 64'd0);
        idle();
    endtask

    task automatic t_logic();
        put(AND_, 64'hF0F0, 64'hFF00, 0);  chk("R10 and", res, 64'hF000);
        put(BIC,  64'hF0F0, 64'hFF00, 0);  chk("R10 bic", res, 64'h00F0);
        put(OR_,  64'hF0F0, 64'hFF00, 0);  chk("R10 or",  res, 64'hFFF0);
        put(XOR_, 64'hF0F0, 64'hFF00, 0);  chk("R10 xor", res, 64'h0FF0);
        put(SLL,  64'd1, 64'd127, 0);      chk("R10 sll count mod 64", res, 64'h8000_0000_0000_0000);
        put(SRL,  64'h8000_0000_0000_0000, 64'd4, 0); chk("R10 srl", res, 64'h0800_0000_0000_0000);
        put(SRA,  64'h8000_0000_0000_0000, 64'd4, 0); chk("R10 sra", res, 64'hF800_0000_0000_0000);
        idle();
    endtask

    task automatic t_cmov();
        put(CMOVEQ, 64'd0, 64'd42, 0);
        chk("R11 cmoveq taken wr", 64'(wr_en), 1);
        chk("R11 cmoveq value", res, 64'd42);
        put(CMOVEQ, 64'd1, 64'd42, 0);
        chk("R11 cmoveq not taken", 64'(wr_en), 0);
        put(CMOVNE, 64'd0, 64'd42, 0);
        chk("R11 cmovne not taken", 64'(wr_en), 0);
        put(CMOVLT, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 0);
        chk("R11 cmovlt taken", 64'(wr_en), 1);
        put(CMOVGE, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 0);
        chk("R11 cmovge not taken", 64'(wr_en), 0);
        idle();
    endtask

    task automatic t_illegal();
        put(6'd63, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1);
        chk("R12 illegal flag", 64'(illegal), 1);
        chk("R12 no write", 64'(wr_en), 0);
        chk("R12 no trap", 64'(ovf_trap), 0);
        chk("R12 no valid", 64'(res_valid), 0);
        put(6'd26, 64'd1, 64'd1, 0);
        chk("R12 first undefined code", 64'(illegal), 1);
        idle();
    endtask

    task automatic t_r31_dest();
        put(ADDQ, 64'd2, 64'd3, 0);
        rc_idx = 31; #1;
        chk("R13 no write to 31", 64'(wr_en), 0);
        chk("R13 result still valid", 64'(res_valid), 1);
        put(UMULH, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0);
        rc_idx = 31; #1;
        @(posedge clk); #1;
        chk("R13 mulhi valid", 64'(mul_valid), 1);
        chk("R13 mulhi no write", 64'(mul_wr_en), 0);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_zero_reg();
        t_literal();
        t_quad();
        t_long();
        t_trap();
        t_mul();
        t_umulh(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        t_umulh(64'h8000_0000_0000_0000, 64'd4);
        t_scaled();
        t_cmp();
        t_logic();
        t_cmov();
        t_illegal();
        t_r31_dest();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule